// File: doc/BRIEF.md
# SMBus Host Block-Transfer Sequencer

This block runs SMBus block write and block read messages on the host side, handing every data byte across to software one byte at a time. Software programs a slave address, a command code and a byte count through a small register window. It sets a start bit, and the sequencer then drives a byte-level bus engine with start, send, receive and stop requests. No FIFO is used. Every data byte passes through one data register, and a byte-done status bit handles the handshake for each byte.

On a block write, software loads each byte and then clears byte-done to release it. On a block read, software collects each byte and clears byte-done to fetch the next one. Before the final read byte, software arms a last-byte control bit so that the final byte is answered with NACK. After the final byte has been handed over, a completion flag raises one more interrupt. An n-byte block therefore produces n+1 interrupts.

Top module: `smb_blk_seq`

Register offsets on `reg_addr`: 0 = address (bits [7:1] hold the slave address, bit 0 is the direction, 1 = read); 1 = command; 2 = count; 3 = data; 4 = status; 5 = control. Status bits: [0] byte-done, [1] completion, [2] device error, [3] count error, [7] busy (read-only). Control bits: [0] start (self-clearing), [1] last-byte, [2] I2C-style write, [3] byte-done interrupt enable, [4] completion/error interrupt enable. Engine operation codes on `eng_op`: 0 = start, 1 = send, 2 = receive, 3 = stop. `eng_ack` high means the slave acknowledged.

## Requirements
- R1: A block write issues, in order, start with byte {addr,0}, send command, send count, send each data byte, then stop.
- R2: A start with the count register equal to zero sets status bit 3 and makes no engine request.
- R3: After each written data byte, status bit 0 is set. The next data byte is not sent until software has both written register 3 and cleared status bit 0.
- R4: A block read issues start {addr,0}, send command, start {addr,1}, receive count, then one receive per data byte. The received count is stored in register 2 and each data byte in register 3. The next receive waits until status bit 0 is cleared.
- R5: In a read, the count byte and every data byte are received with ACK (eng_nack low), except the byte fetched after control bit 1 was set, which uses NACK. A stop follows the final byte.
- R6: irq = (status bit0 AND control bit3) OR ((status bit1 OR bit2 OR bit3) AND control bit4). An n-byte block gives n+1 rising edges of irq.
- R7: When software clears byte-done after the final byte, the sequencer issues a stop and then sets status bit 1.
- R8: With control bit 2 set, a block write omits the count byte but still sends as many data bytes as the count register holds.
- R9: Status bit 7 is high from the start to the end of the message. Writes to registers 0, 1 and 2 while busy are ignored.
- R10: A missing acknowledge on the address or on a written byte ends the message with a stop and sets status bit 2 instead of bit 1.
- R11: Status bits 0 to 3 are cleared by writing one to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| eng_req | output | 1 | Engine request, held until eng_done |
| eng_op | output | 2 | Engine operation code |
| eng_tx | output | 8 | Byte to transmit (start or send) |
| eng_nack | output | 1 | Answer the received byte with NACK |
| eng_done | input | 1 | Engine finished the current operation |
| eng_ack | input | 1 | Slave acknowledged the address or byte |
| eng_rx | input | 8 | Byte received by the engine |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the invariants that hold on every cycle. No engine request is made while byte-done is pending or while the block is idle. NACK is only requested on a receive. When busy falls, exactly one of completion or device error is set. A count error never coexists with busy. Only the bench scenarios can show the byte order of whole messages, the count and I2C variants, the placement of NACK relative to the last-byte bit, the n+1 interrupt count, the hold-off until software releases a byte, and writes ignored while busy.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;
    localparam int DW = 8;
    localparam int AW = 3;

    localparam logic [AW-1:0] RA_ADDR = 3'd0;
    localparam logic [AW-1:0] RA_CMD  = 3'd1;
    localparam logic [AW-1:0] RA_CNT  = 3'd2;
    localparam logic [AW-1:0] RA_DAT  = 3'd3;
    localparam logic [AW-1:0] RA_STAT = 3'd4;
    localparam logic [AW-1:0] RA_CTRL = 3'd5;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_STOP  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE, S_BUS, S_WAIT, S_FINAL
    } st_e;

    typedef enum logic [2:0] {
        PH_ADDR, PH_CMD, PH_CNT, PH_DATA, PH_RADDR, PH_RCNT, PH_RDATA, PH_STOP
    } ph_e;

    typedef struct packed {
        st_e          st;
        ph_e          ph;
        logic         busy;
        logic         rd;
        logic         bd;
        logic         intr;
        logic         derr;
        logic         cerr;
        logic         fresh;
        logic         err;
        logic         nack;
        logic         last;
        logic         i2c;
        logic         ieb;
        logic         ied;
        logic [DW-1:0] rem;
        logic [DW-1:0] addr;
        logic [DW-1:0] cmd;
        logic [DW-1:0] cnt;
        logic [DW-1:0] dat;
    } seq_t;
endpackage

// File: rtl/smb_blk_irq.sv
module smb_blk_irq (
    input  logic bd,
    input  logic intr,
    input  logic derr,
    input  logic cerr,
    input  logic ieb,
    input  logic ied,
    output logic irq
);
    always_comb begin
        irq = (bd & ieb) | ((intr | derr | cerr) & ied);
    end
endmodule

// File: rtl/smb_blk_rmux.sv
module smb_blk_rmux
    import smb_blk_pkg::*;
(
    input  logic [AW-1:0] sel,
    input  seq_t          r,
    output logic [DW-1:0] data
);
    always_comb begin
        data = '0;
        case (sel)
            RA_ADDR: data = r.addr;
            RA_CMD:  data = r.cmd;
            RA_CNT:  data = r.cnt;
            RA_DAT:  data = r.dat;
            RA_STAT: data = {r.busy, 3'b000, r.cerr, r.derr, r.intr, r.bd};
            RA_CTRL: data = {3'b000, r.ied, r.ieb, r.i2c, r.last, 1'b0};
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/smb_blk_seq.sv
module smb_blk_seq
    import smb_blk_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          eng_req,
    output logic [1:0]    eng_op,
    output logic [DW-1:0] eng_tx,
    output logic          eng_nack,
    input  logic          eng_done,
    input  logic          eng_ack,
    input  logic [DW-1:0] eng_rx,
    output logic          irq
);
    seq_t q, d;

    always_comb begin
        d = q;
        // register window
        if (reg_wr) begin
            case (reg_addr)
                RA_ADDR: if (!q.busy) d.addr = reg_wdata;
                RA_CMD:  if (!q.busy) d.cmd  = reg_wdata;
                RA_CNT:  if (!q.busy) d.cnt  = reg_wdata;
                RA_DAT: begin
                    d.dat   = reg_wdata;
                    d.fresh = 1'b1;
                end
                RA_STAT: begin
                    if (reg_wdata[0]) d.bd   = 1'b0;
                    if (reg_wdata[1]) d.intr = 1'b0;
                    if (reg_wdata[2]) d.derr = 1'b0;
                    if (reg_wdata[3]) d.cerr = 1'b0;
                end
                RA_CTRL: begin
                    d.last = reg_wdata[1];
                    d.i2c  = reg_wdata[2];
                    d.ieb  = reg_wdata[3];
                    d.ied  = reg_wdata[4];
                    if (reg_wdata[0] && !q.busy) begin
                        d.bd   = 1'b0;
                        d.intr = 1'b0;
                        d.derr = 1'b0;
                        d.cerr = 1'b0;
                        if (q.cnt == '0) begin
                            d.cerr = 1'b1;
                        end else begin
                            d.busy = 1'b1;
                            d.st   = S_BUS;
                            d.ph   = PH_ADDR;
                            d.rem  = q.cnt;
                            d.err  = 1'b0;
                            d.nack = 1'b0;
                            d.rd   = q.addr[0];
                        end
                    end
                end
                default: ;
            endcase
        end
        // message sequencing
        case (q.st)
            S_BUS: if (eng_done) begin
                case (q.ph)
                    PH_ADDR, PH_CNT, PH_RADDR, PH_CMD, PH_DATA: begin
                        if (!eng_ack) begin
                            d.err = 1'b1;
                            d.ph  = PH_STOP;
                        end else begin
                            case (q.ph)
                                PH_ADDR:  d.ph = PH_CMD;
                                PH_RADDR: d.ph = PH_RCNT;
                                PH_CNT:   d.st = S_WAIT;
                                PH_CMD: begin
                                    if (q.rd)       d.ph = PH_RADDR;
                                    else if (q.i2c) d.st = S_WAIT;
                                    else            d.ph = PH_CNT;
                                end
                                default: begin
                                    d.bd    = 1'b1;
                                    d.fresh = 1'b0;
                                    d.rem   = q.rem - 1'b1;
                                    d.st    = (q.rem == 8'd1) ? S_FINAL : S_WAIT;
                                end
                            endcase
                        end
                    end
                    PH_RCNT: begin
                        d.cnt = eng_rx;
                        d.rem = eng_rx;
                        if (eng_rx == '0) begin
                            d.err = 1'b1;
                            d.ph  = PH_STOP;
                        end else begin
                            d.ph   = PH_RDATA;
                            d.nack = q.last;
                            if (q.last) d.last = 1'b0;
                        end
                    end
                    PH_RDATA: begin
                        d.dat  = eng_rx;
                        d.bd   = 1'b1;
                        d.rem  = q.rem - 1'b1;
                        d.st   = (q.rem == 8'd1 || q.nack) ? S_FINAL : S_WAIT;
                        d.nack = 1'b0;
                    end
                    default: begin
                        d.st   = S_IDLE;
                        d.busy = 1'b0;
                        if (q.err) d.derr = 1'b1;
                        else       d.intr = 1'b1;
                    end
                endcase
            end
            S_WAIT: begin
                if (q.rd) begin
                    if (!q.bd) begin
                        d.st   = S_BUS;
                        d.ph   = PH_RDATA;
                        d.nack = q.last;
                        if (q.last) d.last = 1'b0;
                    end
                end else if (!q.bd && q.fresh) begin
                    d.st = S_BUS;
                    d.ph = PH_DATA;
                end
            end
            S_FINAL: begin
                if (!q.bd) begin
                    d.st = S_BUS;
                    d.ph = PH_STOP;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
            q.ph <= PH_ADDR;
        end else begin
            q <= d;
        end
    end

    // engine drive
    always_comb begin
        eng_req  = (q.st == S_BUS);
        eng_nack = (q.st == S_BUS) && (q.ph == PH_RDATA) && q.nack;
        eng_op   = OP_SEND;
        eng_tx   = '0;
        case (q.ph)
            PH_ADDR:  begin eng_op = OP_START; eng_tx = {q.addr[DW-1:1], 1'b0}; end
            PH_RADDR: begin eng_op = OP_START; eng_tx = {q.addr[DW-1:1], 1'b1}; end
            PH_CMD:   eng_tx = q.cmd;
            PH_CNT:   eng_tx = q.cnt;
            PH_DATA:  eng_tx = q.dat;
            PH_RCNT, PH_RDATA: eng_op = OP_RECV;
            default:  eng_op = OP_STOP;
        endcase
    end

    smb_blk_rmux u_rmux (
        .sel  (reg_addr),
        .r    (q),
        .data (reg_rdata)
    );

    smb_blk_irq u_irq (
        .bd   (q.bd),
        .intr (q.intr),
        .derr (q.derr),
        .cerr (q.cerr),
        .ieb  (q.ieb),
        .ied  (q.ied),
        .irq  (irq)
    );
endmodule

// File: rtl/smb_blk_chk.sv
module smb_blk_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       eng_req,
    input logic [1:0] eng_op,
    input logic       eng_nack,
    input logic       busy,
    input logic       bd,
    input logic       intr,
    input logic       derr,
    input logic       cerr
);
    // R3 / R4: no bus traffic while a byte waits for software
    a_r3_no_bus_while_bd: assert property (@(posedge clk) disable iff (!rst_n)
        bd |-> !eng_req);
    // R5: NACK only accompanies a receive
    a_r5_nack_on_recv: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_nack) |-> (eng_op == 2'd2));
    // R7 / R10: end of message raises completion or device error
    a_r7_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (intr || derr));
    // R10: device error replaces completion
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(intr && derr));
    // R9: requests only while busy
    a_r9_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> busy);
    // R2: a rejected start leaves the block idle
    a_r2_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cerr |-> !busy);
endmodule

bind smb_blk_seq smb_blk_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .eng_req  (eng_req),
    .eng_op   (eng_op),
    .eng_nack (eng_nack),
    .busy     (q.busy),
    .bd       (q.bd),
    .intr     (q.intr),
    .derr     (q.derr),
    .cerr     (q.cerr)
);

// File: tb/tb_smb_blk_seq.sv
module tb_smb_blk_seq;
    localparam int CLK_P = 10;
    localparam logic [6:0] SADR = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       eng_req;
    logic [1:0] eng_op;
    logic [7:0] eng_tx;
    logic       eng_nack;
    logic       eng_done = 1'b0;
    logic       eng_ack = 1'b0;
    logic [7:0] eng_rx = '0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int logn = 0;
    int recv_n = 0;
    int fail_at = -1;
    int rx_cnt = 0;
    int irq_rises = 0;
    logic irq_p = 1'b0;
    bit finished = 0;
    logic [1:0] lop [0:63];
    logic [7:0] lbyte [0:63];
    logic       lnack [0:63];

    always #(CLK_P/2) clk = ~clk;

    smb_blk_seq dut (.*);

    always @(posedge clk) begin
        irq_p <= irq;
        if (irq && !irq_p) irq_rises <= irq_rises + 1;
    end

    // byte-level engine model
    initial begin
        forever begin
            @(negedge clk);
            if (eng_req) begin
                int idx;
                logic [7:0] rx;
                idx = logn;
                if (logn < 64) begin
                    lop[logn] = eng_op; lbyte[logn] = eng_tx; lnack[logn] = eng_nack;
                end
                logn++;
                rx = 8'h00;
                if (eng_op == 2'd2) begin
                    rx = (recv_n == 0) ? rx_cnt[7:0] : 8'(8'hA0 + recv_n - 1);
                    recv_n++;
                end
                repeat (2) @(negedge clk);
                eng_done = 1'b1; eng_ack = (idx != fail_at); eng_rx = rx;
                @(negedge clk);
                eng_done = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_bit(input int b, input string req);
        logic [7:0] s;
        int t = 0;
        do begin rd(3'd4, s); t++; end while (!s[b] && t < 3000);
        chk(s[b] == 1'b1, req, s, b);
    endtask

    task automatic chk_log(input int i, input logic [1:0] op, input logic [7:0] b,
                           input logic nk, input string req);
        chk(i < logn && lop[i] == op, req, lop[i], op);
        if (op != 2'd2 && op != 2'd3) chk(lbyte[i] == b, req, lbyte[i], b);
        if (op == 2'd2) chk(lnack[i] == nk, req, lnack[i], nk);
    endtask

    function automatic logic [7:0] dbyte(input int n, input int k);
        return 8'(8'h30 + n * 8 + k);
    endfunction

    task automatic run_write(input int n, input bit i2c);
        logic [7:0] s;
        int base, held, e;
        logn = 0; recv_n = 0;
        wr(3'd0, {SADR, 1'b0}); wr(3'd1, 8'(8'h5C + n)); wr(3'd2, 8'(n));
        wr(3'd3, dbyte(n, 0));
        base = irq_rises;
        wr(3'd5, 8'h19 | (i2c ? 8'h04 : 8'h00));
        for (int k = 0; k < n; k++) begin
            wait_bit(0, "R3 byte-done");
            if (n == 3 && k == 0) begin
                wr(3'd0, 8'h55); rd(3'd0, s);
                chk(s == {SADR, 1'b0}, "R9 addr ignored while busy", s, {SADR, 1'b0});
                rd(3'd4, s);
                chk(s[7] == 1'b1, "R9 busy bit", s[7], 1);
            end
            if (k < n - 1) begin
                if (n == 2) begin
                    wr(3'd4, 8'h01); held = logn;
                    repeat (20) @(negedge clk);
                    chk(logn == held, "R3 hold until data written", logn, held);
                    wr(3'd3, dbyte(n, k + 1));
                end else begin
                    held = logn;
                    wr(3'd3, dbyte(n, k + 1));
                    repeat (20) @(negedge clk);
                    chk(logn == held, "R3 hold until byte-done cleared", logn, held);
                    wr(3'd4, 8'h01);
                end
            end else begin
                wr(3'd4, 8'h01);
            end
        end
        wait_bit(1, "R7 completion");
        repeat (3) @(negedge clk);
        e = 0;
        chk_log(e++, 2'd0, {SADR, 1'b0}, 1'b0, "R1 start");
        chk_log(e++, 2'd1, 8'(8'h5C + n), 1'b0, "R1 command");
        if (!i2c) chk_log(e++, 2'd1, 8'(n), 1'b0, "R1 count");
        for (int k = 0; k < n; k++) chk_log(e++, 2'd1, dbyte(n, k), 1'b0,
                                            i2c ? "R8 data" : "R1 data");
        chk_log(e++, 2'd3, 8'h00, 1'b0, "R7 stop");
        chk(logn == e, i2c ? "R8 length" : "R1 length", logn, e);
        chk(irq_rises - base == n + 1, "R6 n+1 interrupts", irq_rises - base, n + 1);
        rd(3'd4, s);
        chk(s == 8'h02, "R7 status at end", s, 8'h02);
        wr(3'd4, 8'h0F); rd(3'd4, s);
        chk(s == 8'h00, "R11 write-one-to-clear", s, 0);
    endtask

    task automatic run_read(input int n);
        logic [7:0] s;
        int base, held, e;
        logn = 0; recv_n = 0; rx_cnt = n;
        wr(3'd0, {SADR, 1'b1}); wr(3'd1, 8'h71); wr(3'd2, 8'h01);
        base = irq_rises;
        wr(3'd5, (n == 1) ? 8'h1B : 8'h19);
        for (int k = 0; k < n; k++) begin
            wait_bit(0, "R4 byte-done");
            rd(3'd3, s);
            chk(s == 8'(8'hA0 + k), "R4 data register", s, 8'hA0 + k);
            if (k == 0) begin
                rd(3'd2, s);
                chk(s == 8'(n), "R4 count register", s, n);
            end
            if (n == 3 && k == 0) begin
                held = logn;
                repeat (20) @(negedge clk);
                chk(logn == held, "R4 hold until byte-done cleared", logn, held);
            end
            if (k == n - 2) wr(3'd5, 8'h1A);
            wr(3'd4, 8'h01);
        end
        wait_bit(1, "R7 completion read");
        repeat (3) @(negedge clk);
        e = 0;
        chk_log(e++, 2'd0, {SADR, 1'b0}, 1'b0, "R4 start");
        chk_log(e++, 2'd1, 8'h71, 1'b0, "R4 command");
        chk_log(e++, 2'd0, {SADR, 1'b1}, 1'b0, "R4 repeated start");
        chk_log(e++, 2'd2, 8'h00, 1'b0, "R5 count ACK");
        for (int k = 0; k < n; k++)
            chk_log(e++, 2'd2, 8'h00, (k == n - 1), "R5 data ACK/NACK");
        chk_log(e++, 2'd3, 8'h00, 1'b0, "R5 stop after last");
        chk(logn == e, "R4 length", logn, e);
        chk(irq_rises - base == n + 1, "R6 n+1 interrupts read", irq_rises - base, n + 1);
        wr(3'd4, 8'h0F);
    endtask

    task automatic run_abort(input int at);
        logic [7:0] s;
        logn = 0; recv_n = 0; fail_at = at;
        wr(3'd0, {SADR, 1'b0}); wr(3'd1, 8'h12); wr(3'd2, 8'h02); wr(3'd3, 8'h99);
        wr(3'd5, 8'h19);
        wait_bit(2, "R10 device error");
        repeat (3) @(negedge clk);
        chk(logn == at + 2, "R10 stop after nack", logn, at + 2);
        chk(lop[at + 1] == 2'd3, "R10 stop op", lop[at + 1], 3);
        rd(3'd4, s);
        chk(s == 8'h04, "R10 no completion", s, 8'h04);
        chk(irq == 1'b1, "R6 error interrupt", irq, 1);
        fail_at = -1;
        wr(3'd4, 8'h0F);
    endtask

    initial begin
        logic [7:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(3'd4, s);
        chk(s == 8'h00, "R11 reset status", s, 0);
        chk(irq == 1'b0 && eng_req == 1'b0, "R6 reset outputs", {irq, eng_req}, 0);
        // R2: zero count rejected
        logn = 0;
        wr(3'd2, 8'h00); wr(3'd5, 8'h19);
        repeat (10) @(negedge clk);
        rd(3'd4, s);
        chk(s == 8'h08, "R2 count error", s, 8'h08);
        chk(logn == 0, "R2 no bus activity", logn, 0);
        chk(irq == 1'b1, "R6 count error interrupt", irq, 1);
        wr(3'd4, 8'h08);
        for (int n = 1; n <= 4; n++) begin
            run_write(n, 1'b0);
            run_write(n, 1'b1);
        end
        for (int n = 1; n <= 4; n++) run_read(n);
        run_abort(0);
        run_abort(1);
        run_abort(2);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual %0d expected %0d", 150000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule